// File: doc/BRIEF.md
# Fractional PLL Frequency Calculator

This block works out the output frequency of a phase-locked loop from its reference frequency and the divider settings packed into two 32-bit control words. Software or a monitoring engine presents the reference frequency, both words and a mode bit together with a one-cycle start strobe. The block unpacks the feedback multiplier, the reference pre-divider, the output post-divider shift and, in fractional mode, a signed 16-bit fraction. It then forms a 64-bit product with a shift-add multiplier and divides it with a restoring divider that retires one quotient bit per clock. The result comes back with a one-cycle done pulse.

In integer mode the multiplier is the plain multiplier field. In fractional mode the multiplier is the multiplier field times 65536 plus the signed fraction, and the divisor is scaled by 65536 to match. The post-divider always acts as a left shift of the divisor. A zero pre-divider, or a fraction negative enough to make the fractional multiplier negative, is reported through an error flag without starting the arithmetic.

Top module: `pllfreq_calc`

## Requirements
- R1: Field positions in the first control word are multiplier M = bits 21:12, pre-divider P = bits 9:4 and post-divider shift S = bits 2:0; every other bit of that word has no effect on the result.
- R2: With frac_mode = 0 the result is floor(fin * M / (P << S)) and the second control word has no effect.
- R3: With frac_mode = 1 the fraction K is bits 15:0 of the second control word read as two's complement, bits 31:16 of that word have no effect, and the result is floor(fin * (M * 65536 + K) / ((P * 65536) << S)).
- R4: Every accepted start produces exactly one done pulse one cycle wide; freq_out and err keep their values from then until the next done.
- R5: After an accepted start without error, busy is high from the next cycle until completion, and busy falls in the same cycle that done rises; done is never high while busy is high.
- R6: A start with P = 0 gives done one cycle later with err = 1 and freq_out = 0, and busy stays low.
- R7: In fractional mode, a start whose M * 65536 + K is negative gives done one cycle later with err = 1 and freq_out = 0.
- R8: A start strobe that arrives while busy is high is ignored: it produces no done pulse and does not alter the result of the job in progress.
- R9: After reset busy, done, err and freq_out are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request; accepted only when busy is low |
| fin | input | 32 | Reference frequency (unsigned) |
| ctl_word0 | input | 32 | First control word: multiplier, pre-divider, post-divider shift |
| ctl_word1 | input | 32 | Second control word: signed fraction in bits 15:0 |
| frac_mode | input | 1 | 1 selects fractional mode, 0 integer mode |
| busy | output | 1 | A calculation is in progress |
| done | output | 1 | One-cycle pulse: freq_out and err are valid |
| freq_out | output | 64 | Computed frequency, zero on error |
| err | output | 1 | Last job was rejected (zero pre-divider or negative multiplier) |

## Verification
A corrupted partial product or remainder inside the shift loops stays hidden until the final done pulse, roughly a hundred cycles after the start, where it appears as a wrong freq_out; the scoreboard compares every result against a value computed in the bench. A wrong step counter or sequencer state shows earlier and more plainly: busy stays high, done never arrives or arrives twice, and the pending-result queue either starves or reports an unexpected done. A wrongly accepted start during a calculation shows as an extra done pulse at the next completion.

// File: rtl/pllfreq_pkg.sv
package pllfreq_pkg;

  localparam int unsigned CW_W   = 32;
  localparam int unsigned FIN_W  = 32;
  localparam int unsigned PROD_W = 64;

  localparam int unsigned M_W   = 10;
  localparam int unsigned P_W   = 6;
  localparam int unsigned S_W   = 3;
  localparam int unsigned K_W   = 16;

  localparam int unsigned M_LSB = 12;
  localparam int unsigned P_LSB = 4;
  localparam int unsigned S_LSB = 0;
  localparam int unsigned K_LSB = 0;

  // multiplier operand: M scaled by 2^K_W plus signed K, one spare bit
  localparam int unsigned MOP_W = M_W + K_W + 1;
  // divisor: P scaled by 2^K_W then shifted by up to 2^S_W-1
  localparam int unsigned DEN_W = P_W + K_W + (1 << S_W) - 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MUL  = 2'd1,
    ST_DIV  = 2'd2
  } calc_state_e;

endpackage

// File: rtl/pllfreq_unpack.sv
module pllfreq_unpack
  import pllfreq_pkg::*;
(
  input  logic [M_W-1:0]   m_fld,
  input  logic [P_W-1:0]   p_fld,
  input  logic [S_W-1:0]   s_fld,
  input  logic [K_W-1:0]   k_fld,
  input  logic             frac,
  output logic [MOP_W-1:0] mop,
  output logic [DEN_W-1:0] den,
  output logic             bad
);

  logic signed [MOP_W:0] frac_sum;
  logic [DEN_W-1:0]      den_base;
  logic                  p_zero;
  logic                  neg;

  always_comb begin
    frac_sum = $signed({2'b00, m_fld, {K_W{1'b0}}})
             + $signed({{(MOP_W + 1 - K_W){k_fld[K_W-1]}}, k_fld});
    neg      = frac & frac_sum[MOP_W];
    p_zero   = (p_fld == '0);

    if (frac) begin
      mop      = frac_sum[MOP_W-1:0];
      den_base = {{(DEN_W - P_W - K_W){1'b0}}, p_fld, {K_W{1'b0}}};
    end else begin
      mop      = {{(MOP_W - M_W){1'b0}}, m_fld};
      den_base = {{(DEN_W - P_W){1'b0}}, p_fld};
    end

    den = den_base << s_fld;
    bad = p_zero | neg;
  end

endmodule

// File: rtl/pllfreq_mul.sv
module pllfreq_mul #(
  parameter int unsigned A_W = 32,
  parameter int unsigned B_W = 27,
  parameter int unsigned R_W = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [A_W-1:0] a_in,
  input  logic [B_W-1:0] b_in,
  output logic           done,
  output logic [R_W-1:0] prod
);

  localparam int unsigned CNT_W = $clog2(B_W + 1);

  logic [R_W-1:0]   acc_q, acc_d;
  logic [R_W-1:0]   ash_q, ash_d;
  logic [B_W-1:0]   bsh_q, bsh_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             step;
  logic             dp_en;

  assign step  = (cnt_q != '0);
  assign dp_en = load | step;

  always_comb begin
    acc_d  = acc_q;
    ash_d  = ash_q;
    bsh_d  = bsh_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (load) begin
      acc_d = '0;
      ash_d = {{(R_W - A_W){1'b0}}, a_in};
      bsh_d = b_in;
      cnt_d = CNT_W'(B_W);
    end else if (step) begin
      if (bsh_q[0]) begin
        acc_d = acc_q + ash_q;
      end
      ash_d  = ash_q << 1;
      bsh_d  = bsh_q >> 1;
      cnt_d  = cnt_q - 1'b1;
      done_d = (cnt_q == CNT_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ash_q <= '0;
      bsh_q <= '0;
      cnt_q <= '0;
    end else if (dp_en) begin
      acc_q <= acc_d;
      ash_q <= ash_d;
      bsh_q <= bsh_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
    end
  end

  assign done = done_q;
  assign prod = acc_q;

endmodule

// File: rtl/pllfreq_div.sv
module pllfreq_div #(
  parameter int unsigned N_W = 64,
  parameter int unsigned D_W = 29
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [N_W-1:0] num,
  input  logic [D_W-1:0] den,
  output logic           done,
  output logic [N_W-1:0] quo
);

  localparam int unsigned CNT_W = $clog2(N_W + 1);

  logic [D_W-1:0]   rem_q, rem_d;
  logic [N_W-1:0]   quo_q, quo_d;
  logic [D_W-1:0]   den_q, den_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic [D_W:0]     trial;
  logic [D_W:0]     diff;
  logic             fits;
  logic             step;
  logic             dp_en;

  assign step  = (cnt_q != '0);
  assign dp_en = load | step;

  always_comb begin
    trial  = {rem_q, quo_q[N_W-1]};
    diff   = trial - {1'b0, den_q};
    fits   = (trial >= {1'b0, den_q});
    rem_d  = rem_q;
    quo_d  = quo_q;
    den_d  = den_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (load) begin
      rem_d = '0;
      quo_d = num;
      den_d = den;
      cnt_d = CNT_W'(N_W);
    end else if (step) begin
      rem_d  = fits ? diff[D_W-1:0] : trial[D_W-1:0];
      quo_d  = {quo_q[N_W-2:0], fits};
      cnt_d  = cnt_q - 1'b1;
      done_d = (cnt_q == CNT_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      den_q <= '0;
      cnt_q <= '0;
    end else if (dp_en) begin
      rem_q <= rem_d;
      quo_q <= quo_d;
      den_q <= den_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
    end
  end

  assign done = done_q;
  assign quo  = quo_q;

endmodule

// File: rtl/pllfreq_calc.sv
module pllfreq_calc
  import pllfreq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [FIN_W-1:0]  fin,
  input  logic [CW_W-1:0]   ctl_word0,
  input  logic [CW_W-1:0]   ctl_word1,
  input  logic              frac_mode,
  output logic              busy,
  output logic              done,
  output logic [PROD_W-1:0] freq_out,
  output logic              err
);

  calc_state_e       state_q, state_d;
  logic [PROD_W-1:0] res_q, res_d;
  logic              err_q, err_d;
  logic              done_q, done_d;
  logic [DEN_W-1:0]  den_hold_q;
  logic              den_en;
  logic              res_en;

  logic [MOP_W-1:0]  mop;
  logic [DEN_W-1:0]  den;
  logic              bad;

  logic              mul_load, mul_done;
  logic [PROD_W-1:0] mul_prod;
  logic              div_load, div_done;
  logic [PROD_W-1:0] div_quo;

  logic              unused_ctl_bits;
  assign unused_ctl_bits = ^{ctl_word0[CW_W-1:M_LSB+M_W],
                             ctl_word0[M_LSB-1:P_LSB+P_W],
                             ctl_word0[P_LSB-1:S_LSB+S_W],
                             ctl_word1[CW_W-1:K_LSB+K_W]};

  pllfreq_unpack u_unpack (
    .m_fld (ctl_word0[M_LSB +: M_W]),
    .p_fld (ctl_word0[P_LSB +: P_W]),
    .s_fld (ctl_word0[S_LSB +: S_W]),
    .k_fld (ctl_word1[K_LSB +: K_W]),
    .frac  (frac_mode),
    .mop   (mop),
    .den   (den),
    .bad   (bad)
  );

  pllfreq_mul #(
    .A_W (FIN_W),
    .B_W (MOP_W),
    .R_W (PROD_W)
  ) u_mul (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (mul_load),
    .a_in  (fin),
    .b_in  (mop),
    .done  (mul_done),
    .prod  (mul_prod)
  );

  pllfreq_div #(
    .N_W (PROD_W),
    .D_W (DEN_W)
  ) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (div_load),
    .num   (mul_prod),
    .den   (den_hold_q),
    .done  (div_done),
    .quo   (div_quo)
  );

  always_comb begin
    state_d  = state_q;
    res_d    = res_q;
    err_d    = err_q;
    done_d   = 1'b0;
    res_en   = 1'b0;
    mul_load = 1'b0;
    div_load = 1'b0;
    den_en   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (bad) begin
            res_d  = '0;
            err_d  = 1'b1;
            done_d = 1'b1;
            res_en = 1'b1;
          end else begin
            mul_load = 1'b1;
            den_en   = 1'b1;
            state_d  = ST_MUL;
          end
        end
      end
      ST_MUL: begin
        if (mul_done) begin
          div_load = 1'b1;
          state_d  = ST_DIV;
        end
      end
      ST_DIV: begin
        if (div_done) begin
          res_d   = div_quo;
          err_d   = 1'b0;
          done_d  = 1'b1;
          res_en  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      err_q <= 1'b0;
    end else if (res_en) begin
      res_q <= res_d;
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      den_hold_q <= '0;
    end else if (den_en) begin
      den_hold_q <= den;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign freq_out = res_q;
  assign err      = err_q;

endmodule

// File: rtl/pllfreq_calc_chk.sv
module pllfreq_calc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [31:0] ctl_word0,
  input logic [31:0] ctl_word1,
  input logic        frac_mode,
  input logic        busy,
  input logic        done,
  input logic [63:0] freq_out,
  input logic        err
);

  logic pz;
  logic negk;
  logic idle_start;
  logic unused_chk_bits;

  assign pz         = (ctl_word0[9:4] == 6'd0);
  assign negk       = frac_mode && (ctl_word0[21:12] == 10'd0) && ctl_word1[15];
  assign idle_start = start && !busy;
  assign unused_chk_bits = ^{ctl_word0[31:22], ctl_word0[11:10], ctl_word0[3:0],
                             ctl_word1[31:16], ctl_word1[14:0]};

  // R6: zero pre-divider rejected on the next cycle
  a_r6_pdiv_zero: assert property (@(posedge clk) disable iff (!rst_n)
    idle_start && pz |=> done && err && !busy && (freq_out == 64'd0));

  // R7: negative fractional multiplier rejected on the next cycle
  a_r7_neg_mult: assert property (@(posedge clk) disable iff (!rst_n)
    idle_start && !pz && negk |=> done && err && (freq_out == 64'd0));

  // R5: a valid start raises busy
  a_r5_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    idle_start && !pz && !negk |=> busy);

  // R5: busy ends only with the done pulse
  a_r5_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R5: done never while busy
  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R4: outputs hold between completions
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(freq_out) && $stable(err));

  // R8: a start during a calculation keeps the block busy
  a_r8_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    start && busy |=> busy || done);

endmodule

bind pllfreq_calc pllfreq_calc_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .ctl_word0 (ctl_word0),
  .ctl_word1 (ctl_word1),
  .frac_mode (frac_mode),
  .busy      (busy),
  .done      (done),
  .freq_out  (freq_out),
  .err       (err)
);

// File: tb/test_pllfreq_calc.sv
module test_pllfreq_calc;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 100000;

  typedef struct {
    logic [63:0] res;
    logic        err;
    string       tag;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [31:0] fin;
  logic [31:0] ctl_word0;
  logic [31:0] ctl_word1;
  logic        frac_mode;
  logic        busy;
  logic        done;
  logic [63:0] freq_out;
  logic        err;

  int   n_checks;
  int   n_fails;
  exp_t sb_q[$];
  logic [63:0] last_res;

  pllfreq_calc i_pllfreq_calc (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .fin       (fin),
    .ctl_word0 (ctl_word0),
    .ctl_word1 (ctl_word1),
    .frac_mode (frac_mode),
    .busy      (busy),
    .done      (done),
    .freq_out  (freq_out),
    .err       (err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_w0(input int m, input int p, input int s,
                                        input logic [31:0] junk);
    logic [31:0] w;
    w = junk & ~32'h003F_FFF7;
    w[21:12] = m[9:0];
    w[9:4]   = p[5:0];
    w[2:0]   = s[2:0];
    return w;
  endfunction

  function automatic exp_t model(input logic [31:0] f, input logic [31:0] w0,
                                 input logic [31:0] w1, input logic fr,
                                 input string tag);
    exp_t e;
    longint mop;
    longint unsigned den;
    longint unsigned m, p, s;
    m = longint'(w0[21:12]);
    p = longint'(w0[9:4]);
    s = longint'(w0[2:0]);
    if (fr) mop = longint'(m) * 65536 + longint'($signed(w1[15:0]));
    else    mop = longint'(m);
    e.tag = tag;
    if (p == 0 || mop < 0) begin
      e.res = 64'd0;
      e.err = 1'b1;
    end else begin
      den   = fr ? ((p * 65536) << s) : (p << s);
      e.res = (longint'(f) * longint'(mop)) / den;
      e.err = 1'b0;
    end
    return e;
  endfunction

  task automatic run_job(input logic [31:0] f, input logic [31:0] w0,
                         input logic [31:0] w1, input logic fr, input string tag);
    exp_t e;
    while (busy) @(negedge clk);
    e = model(f, w0, w1, fr, tag);
    sb_q.push_back(e);
    fin       = f;
    ctl_word0 = w0;
    ctl_word1 = w1;
    frac_mode = fr;
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (e.err) begin
      check(done && err && !busy, {tag, " R6/R7 early reject"},
            {62'd0, busy, done}, 64'd1);
    end else begin
      check(busy, {tag, " R5 busy after start"}, {63'd0, busy}, 64'd1);
    end
  endtask

  task automatic drain();
    while (busy || sb_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R8 R4 done with no pending job", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(freq_out == e.res, {e.tag, " result"}, freq_out, e.res);
        check(err == e.err, {e.tag, " err flag"}, {63'd0, err}, {63'd0, e.err});
        last_res = freq_out;
      end
    end
  end

  initial begin
    repeat (WDOG_LIMIT) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", WDOG_LIMIT);
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    n_checks  = 0;
    n_fails   = 0;
    last_res  = '0;
    rst_n     = 1'b0;
    start     = 1'b0;
    fin       = '0;
    ctl_word0 = '0;
    ctl_word1 = '0;
    frac_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    check(!busy && !done && !err && freq_out == 0, "R9 reset state",
          {freq_out[60:0], busy, done, err}, 64'd0);

    // R2 integer mode, word1 junk ignored
    run_job(32'd24_000_000, mk_w0(225, 3, 0, 32'h0), 32'hDEAD_BEEF, 1'b0, "R2 int s0");
    run_job(32'd24_000_000, mk_w0(375, 3, 1, 32'h0), 32'h0, 1'b0, "R2 int s1");
    run_job(32'd24_000_000, mk_w0(350, 3, 2, 32'h0), 32'h1234_8000, 1'b0, "R2 int s2");
    run_job(32'hFFFF_FFFF, mk_w0(1023, 1, 0, 32'h0), 32'h0, 1'b0, "R2 int max");
    run_job(32'd1000, mk_w0(1, 63, 7, 32'h0), 32'h0, 1'b0, "R2 int trunc zero");
    // R1 junk outside the fields of word0
    run_job(32'd24_000_000, mk_w0(200, 3, 1, 32'hFFFF_FFFF), 32'h0, 1'b0, "R1 int junk");
    run_job(32'd24_000_000, mk_w0(173, 2, 1, 32'hA5A5_A5A5), 32'hFFFF_4000, 1'b1, "R1 frac junk");

    // R3 fractional mode
    run_job(32'd24_000_000, mk_w0(173, 2, 1, 32'h0), 32'h0000_4000, 1'b1, "R3 frac pos");
    run_job(32'd24_000_000, mk_w0(262, 2, 3, 32'h0), 32'h0000_24DD, 1'b1, "R3 frac s3");
    run_job(32'd24_000_000, mk_w0(262, 2, 3, 32'h0), 32'h0000_FF9C, 1'b1, "R3 frac neg k");
    run_job(32'd24_000_000, mk_w0(0, 1, 0, 32'h0), 32'h0000_0005, 1'b1, "R3 frac m0 pos");
    run_job(32'd24_000_000, mk_w0(325, 3, 2, 32'h0), 32'h0, 1'b1, "R3 frac k0");

    // R6 zero pre-divider, both modes
    run_job(32'd24_000_000, mk_w0(200, 0, 1, 32'h0), 32'h0, 1'b0, "R6 pdiv0 int");
    run_job(32'd24_000_000, mk_w0(200, 0, 1, 32'h0), 32'h0, 1'b1, "R6 pdiv0 frac");
    // R7 negative fractional multiplier; same fields in integer mode are fine
    run_job(32'd24_000_000, mk_w0(0, 3, 0, 32'h0), 32'h0000_FFFF, 1'b1, "R7 neg mult");
    run_job(32'd24_000_000, mk_w0(0, 3, 0, 32'h0), 32'h0000_FFFF, 1'b0, "R7 int no neg");
    drain();

    // R4 result holds after completion
    run_job(32'd24_000_000, mk_w0(250, 2, 2, 32'h0), 32'h0, 1'b0, "R4 setup");
    drain();
    repeat (5) @(negedge clk);
    check(freq_out == last_res && !done, "R4 hold", freq_out, last_res);

    // R8 start while busy ignored
    run_job(32'd24_000_000, mk_w0(300, 3, 1, 32'h0), 32'h0, 1'b0, "R8 first job");
    repeat (10) @(negedge clk);
    fin       = 32'd5;
    ctl_word0 = mk_w0(7, 0, 0, 32'h0);
    frac_mode = 1'b1;
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy && !done, "R8 still busy", {62'd0, busy, done}, 64'd2);
    drain();
    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R8 queue empty", sb_q.size(), 64'd0);

    // mixed patterns
    for (int i = 0; i < 16; i++) begin
      logic [31:0] f, w0, w1;
      f  = $urandom;
      w0 = $urandom;
      w1 = $urandom;
      run_job(f, w0, w1, i[0], (i[0] ? "R3 mixed" : "R2 mixed"));
    end
    drain();
    check(sb_q.size() == 0, "R4 all jobs completed", sb_q.size(), 64'd0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule